// File: doc/BRIEF.md
# Strobe-Handshake Parallel FIFO

This block is a first-in first-out buffer of 64 words, each 4 or 5 bits wide. It is built around a dual-port memory with separate write and read pointers. A producer presents a word and raises the shift-in strobe. The FIFO takes the word on that rising edge and lowers its input-ready flag. When the strobe falls, the word is committed and the flag returns high, unless the buffer is now full.

The read side works the same way in reverse. While output-ready is high, the output holds the oldest word. A rising shift-out strobe acknowledges that word and drops output-ready. The falling edge retires the word, and output-ready comes back with the next word if one is stored.

Because output-ready behaves like a shift-in strobe, several instances can be chained one after another. Both strobes are sampled in one system clock domain. An active-low output enable releases the data bus to high impedance.

Top module: `siso_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the FIFO is emptied. After that edge `in_ready` is 1, `out_ready` is 0 and `dout` is 0 (with `oe_n` low).
- R2: A clock edge that samples `shift_in` high after it was low, while `in_ready` is 1, stores `din`. `in_ready` is 0 after that edge.
- R3: The first edge that samples `shift_in` low after an accepted rise commits the word. `in_ready` is 1 after that edge unless 64 words are now stored.
- R4: While 64 words are stored, `in_ready` stays 0. It becomes 1 after the edge that retires a word through a shift-out fall.
- R5: A `shift_in` rise sampled while `in_ready` is 0 is ignored. No word is added and the stored words are unchanged.
- R6: After the edge that commits a word into an empty FIFO with no read in progress, `out_ready` is 1 and `dout` shows that word.
- R7: A `shift_out` rise sampled while `out_ready` is 1 makes `out_ready` 0 after that edge.
- R8: The first edge sampling `shift_out` low after an accepted rise retires the word. After it, `out_ready` is 1 with the next word on `dout` if any remains, otherwise 0.
- R9: A `shift_out` rise sampled while `out_ready` is 0 is ignored.
- R10: A commit and a retire on the same edge both take effect, so the stored count is unchanged.
- R11: With `oe_n` high, `dout` is high impedance. With `oe_n` low, `dout` drives the held word.
- R12: Words leave in the order they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous master reset, active low |
| shift_in | input | 1 | Write strobe: rise captures, fall commits |
| din | input | WIDTH | Word to write |
| in_ready | output | 1 | High when a new word may be shifted in |
| shift_out | input | 1 | Read strobe: rise acknowledges, fall retires |
| out_ready | output | 1 | High when `dout` holds a valid word |
| oe_n | input | 1 | Output enable, active low |
| dout | output | WIDTH | Oldest word, or high impedance when disabled |

## Verification
Every flag change is due exactly one clock edge after the strobe sample that causes it. A rise lowers its ready flag on that edge. A fall raises the flags and loads the next word on that same edge. The output enable acts on `dout` with no clock delay.

The bench drives all inputs on falling edges and updates a queue-based model on each rising edge. It compares the flags and the bus at the following falling edge, so each result is read half a period after the edge that produced it. Directed checks follow the same pattern: change a strobe, wait one falling edge, then check the flag the requirement names.

// File: rtl/siso_pkg.sv
package siso_pkg;
  // Phase of a two-step strobe transfer on either side of the FIFO.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HELD = 1'b1
  } phase_e;
endpackage

// File: rtl/siso_strobe.sv
module siso_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/siso_dpram.sv
module siso_dpram #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with synchronous output reset.
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/siso_fifo.sv
module siso_fifo
  import siso_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  input  logic             oe_n,
  output logic [WIDTH-1:0] dout
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic si_rise, si_fall, so_rise, so_fall;
  phase_e wr_ph, rd_ph, wr_ph_n, rd_ph_n;
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] count, count_n;
  logic ir_q, or_q;
  logic accept_wr, accept_rd, commit, pop, avail_n;
  logic [WIDTH-1:0] q_word;

  siso_strobe u_si (.clk(clk), .rst_n(rst_n), .level(shift_in),  .rise(si_rise), .fall(si_fall));
  siso_strobe u_so (.clk(clk), .rst_n(rst_n), .level(shift_out), .rise(so_rise), .fall(so_fall));

  always_comb begin
    accept_wr = si_rise && ir_q;
    commit    = si_fall && (wr_ph == PH_HELD);
    accept_rd = so_rise && or_q;
    pop       = so_fall && (rd_ph == PH_HELD);

    wr_ph_n = wr_ph;
    if (accept_wr)   wr_ph_n = PH_HELD;
    else if (commit) wr_ph_n = PH_IDLE;

    rd_ph_n = rd_ph;
    if (accept_rd) rd_ph_n = PH_HELD;
    else if (pop)  rd_ph_n = PH_IDLE;

    wptr_n = wptr;
    if (commit) wptr_n = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
    rptr_n = rptr;
    if (pop) rptr_n = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;

    count_n = count;
    if (commit && !pop)      count_n = count + 1'b1;
    else if (pop && !commit) count_n = count - 1'b1;

    avail_n = (rd_ph_n == PH_IDLE) && (count_n != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ph <= PH_IDLE;
      rd_ph <= PH_IDLE;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ir_q  <= 1'b1;
      or_q  <= 1'b0;
    end else begin
      wr_ph <= wr_ph_n;
      rd_ph <= rd_ph_n;
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
      ir_q  <= (wr_ph_n == PH_IDLE) && (count_n < FULL_CNT);
      or_q  <= avail_n;
    end
  end

  siso_dpram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(accept_wr), .waddr(wptr), .wdata(din),
    .re(avail_n), .raddr(rptr_n), .rdata(q_word)
  );

  assign in_ready  = ir_q;
  assign out_ready = or_q;
  assign dout      = oe_n ? {WIDTH{1'bz}} : q_word;

  // R4
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> !in_ready);
  // R2
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_rise && in_ready) |=> !in_ready);
  // R5
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_rise && !in_ready) |=> $stable(wptr));
  // R7
  rd_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_rise && out_ready) |=> !out_ready);
  // R6
  valid_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> (count != '0));
  // R10
  both_keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pop) |=> $stable(count));
endmodule

// File: tb/siso_fifo_test.sv
module siso_fifo_test;
  localparam int W = 4;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic si = 1'b0, so = 1'b0, oe_n = 1'b0;
  logic [W-1:0] din = '0;
  logic ir, orr;
  logic tb_drive = 1'b0;
  logic [W-1:0] tb_word = '0;
  tri   [W-1:0] bus;

  int checks = 0;
  int errors = 0;

  assign bus = tb_drive ? tb_word : {W{1'bz}};

  always #2 clk = ~clk;

  siso_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .in_ready(ir),
    .shift_out(so), .out_ready(orr), .oe_n(oe_n), .dout(bus)
  );

  // Behavioural reference model
  logic [W-1:0] q[$];
  logic [W-1:0] pend, exp_q;
  bit prev_si, prev_so, wheld, rheld, exp_ir, exp_or, started;

  always @(posedge clk) begin
    started = 1'b1;
    if (!rst_n) begin
      q.delete();
      wheld = 0; rheld = 0; prev_si = 0; prev_so = 0;
      exp_ir = 1; exp_or = 0; exp_q = '0;
    end else begin
      bit sr, sf, rr, rf, c, p;
      sr = si && !prev_si;  sf = !si && prev_si;
      rr = so && !prev_so;  rf = !so && prev_so;
      c = sf && wheld;
      p = rf && rheld;
      if (sr && exp_ir) begin pend = din; wheld = 1; end
      if (rr && exp_or) rheld = 1;
      if (p) begin void'(q.pop_front()); rheld = 0; end
      if (c) begin q.push_back(pend); wheld = 0; end
      exp_ir = !wheld && (q.size() < D);
      exp_or = !rheld && (q.size() > 0);
      if (exp_or) exp_q = q[0];
      prev_si = si; prev_so = so;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Per-clock comparison against the model, half a period after each edge
  always @(negedge clk) begin
    if (started) begin
      check(ir == exp_ir, "R3 in_ready vs model", int'(ir), int'(exp_ir));
      check(orr == exp_or, "R6 out_ready vs model", int'(orr), int'(exp_or));
      if (!oe_n)
        check(bus === exp_q, "R12 dout vs model", int'(bus), int'(exp_q));
    end
  end

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 5 + 3) % (1 << W));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] w);
    si = 1; din = w; tick();
    si = 0; tick();
  endtask

  task automatic pop();
    so = 1; tick();
    so = 0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    check(ir == 1, "R1 in_ready after reset", int'(ir), 1);
    check(orr == 0, "R1 out_ready after reset", int'(orr), 0);
    check(bus === '0, "R1 dout after reset", int'(bus), 0);

    // R9: read strobe on empty FIFO
    so = 1; tick();
    check(orr == 0, "R9 out_ready on empty read", int'(orr), 0);
    so = 0; tick();
    check(orr == 0 && ir == 1, "R9 state unchanged", int'(orr), 0);

    // R2, R3, R6
    si = 1; din = 4'h6; tick();
    check(ir == 0, "R2 in_ready after rise", int'(ir), 0);
    si = 0; tick();
    check(ir == 1, "R3 in_ready after fall", int'(ir), 1);
    check(orr == 1, "R6 out_ready after commit", int'(orr), 1);
    check(bus === 4'h6, "R6 dout word", int'(bus), 6);

    // R7, R8
    so = 1; tick();
    check(orr == 0, "R7 out_ready after read rise", int'(orr), 0);
    so = 0; tick();
    check(orr == 0, "R8 out_ready after last retire", int'(orr), 0);

    // Fill to 64 words
    for (int i = 0; i < D; i++) push(pat(i));
    check(ir == 0, "R4 in_ready when full", int'(ir), 0);
    check(bus === pat(0), "R12 head word", int'(bus), int'(pat(0)));

    // R5: write attempt while full
    push(4'hF);
    check(ir == 0, "R5 in_ready after ignored write", int'(ir), 0);

    pop();
    check(ir == 1, "R4 in_ready after retire from full", int'(ir), 1);
    check(bus === pat(1), "R8 next word after retire", int'(bus), int'(pat(1)));
    for (int i = 1; i < D; i++) begin
      check(bus === pat(i), "R12 order", int'(bus), int'(pat(i)));
      pop();
    end
    check(orr == 0, "R5 no extra word stored", int'(orr), 0);

    // R10: commit and retire on the same edge
    push(4'h1);
    push(4'h2);
    si = 1; din = 4'h3; so = 1; tick();
    si = 0; so = 0; tick();
    check(orr == 1, "R10 out_ready after dual edge", int'(orr), 1);
    check(bus === 4'h2, "R10 next word after dual edge", int'(bus), 2);
    pop();
    check(bus === 4'h3, "R10 remaining word", int'(bus), 3);
    pop();
    check(orr == 0, "R10 count kept", int'(orr), 0);

    // R11: output enable
    oe_n = 1; tb_drive = 1; tb_word = 4'hA; tick();
    check(bus === 4'hA, "R11 bus released", int'(bus), 10);
    tb_drive = 0; oe_n = 0; tick();
    check(bus === 4'h3, "R11 bus driven again", int'(bus), 3);

    repeat (2) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule